// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block follows the open, closed and recovering condition of every bank in an SDRAM device, as seen from the command stream a controller sends. Each cycle it may receive one decoded command: row open, column read, column write or bank close. The command comes with the bank select field and the address bit that widens a close to every bank. For each bank it keeps the row that was opened and a countdown of the close-to-open recovery time. That time is a cycle count the controller supplies. From this state the block reports, per bank, whether a column access or a row open would be legal right now.

A controller can use the per-bank legality flags to schedule commands. A protocol monitor can use the registered violation flag, and the bank it names, to catch an illegal command one cycle after it was issued. The tracker never blocks a command. An illegal command changes nothing, and its only effect is the flag.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset every bank reports idle, `act_ok` is all ones, `rw_ok` is all zeros and `viol` is low. The per-bank state code is 2'b00 for idle, 2'b01 for open and 2'b10 for recovering. Bank b occupies `bank_state[2b+1:2b]`.
- R2: A valid row-open command (`cmd_op` = 2'b00) to an idle bank has these effects from the next cycle on. That bank reports open, and its slice `open_row[ROW_W*b +: ROW_W]` holds `cmd_row`. Its `rw_ok` bit is set and its `act_ok` bit is cleared.
- R3: A valid read (`cmd_op` = 2'b01) or write (`cmd_op` = 2'b10) to a bank that is not open raises `viol` in the following cycle only, with `viol_bank` equal to that bank. No bank state changes because of it. A read or write to an open bank raises nothing.
- R4: A row-open command to a bank that is open or recovering raises `viol` with `viol_bank` set to that bank, and leaves that bank's stored row unchanged.
- R5: A close command (`cmd_op` = 2'b11) with `cmd_a10` low acts only on the bank selected by `cmd_ba`. All other banks keep their state.
- R6: A close command with `cmd_a10` high acts on every bank, whatever the value of `cmd_ba`.
- R7: After a close issued at clock edge k with `trp_cycles` = T, the bank reports recovering until edge k+T. A row open there is legal no earlier than edge k+T. Values of T of 0 or 1 behave as 1, so the bank is idle right after the close.
- R8: A close to a bank that is already idle or recovering is legal and raises no violation. It restarts that bank's recovery count from the current `trp_cycles`.
- R9: While `cmd_valid` is low, no command field has any effect. Recovery counts keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 00 open row, 01 read, 10 write, 11 close |
| cmd_ba | input | $clog2(NUM_BANKS) | Bank select |
| cmd_a10 | input | 1 | On close: high closes all banks |
| cmd_row | input | ROW_W | Row address for open row |
| trp_cycles | input | TRP_W | Close-to-open recovery time in cycles |
| bank_state | output | 2*NUM_BANKS | Per-bank state code |
| open_row | output | ROW_W*NUM_BANKS | Per-bank stored row |
| rw_ok | output | NUM_BANKS | Read/write to the bank is legal now |
| act_ok | output | NUM_BANKS | Row open to the bank is legal now |
| viol | output | 1 | Previous cycle's command was illegal |
| viol_bank | output | $clog2(NUM_BANKS) | Bank of the illegal command, 0 when none |

## Verification
The hardest case to reach is a row open that lands exactly on the last recovering cycle, compared with one that lands a cycle later. The other hard case is a close that arrives while a bank is still recovering and must restart its count. The stimulus issues a close and then row opens on each following cycle, so the boundary edge is crossed with no idle gap. It repeats this with recovery times of 3, 1 and 0. It also overlaps an all-bank close with a single-bank close on a bank that is still counting.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    typedef enum logic [1:0] {
        BANK_IDLE  = 2'b00,
        BANK_OPEN  = 2'b01,
        BANK_PRECH = 2'b10
    } bank_st_e;

    typedef enum logic [1:0] {
        OP_ACT = 2'b00,
        OP_RD  = 2'b01,
        OP_WR  = 2'b10,
        OP_PRE = 2'b11
    } cmd_op_e;

endpackage

// File: rtl/sbt_cmd_route.sv
module sbt_cmd_route
    import sbt_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                         valid_i,
    input  logic [1:0]                   op_i,
    input  logic [$clog2(NUM_BANKS)-1:0] ba_i,
    input  logic                         a10_i,
    output logic [NUM_BANKS-1:0]         act_hit_o,
    output logic [NUM_BANKS-1:0]         rw_hit_o,
    output logic [NUM_BANKS-1:0]         pre_hit_o
);
    localparam int BA_W = $clog2(NUM_BANKS);

    cmd_op_e op;
    assign op = cmd_op_e'(op_i);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
        logic sel;
        assign sel          = (ba_i == BA_W'(b));
        assign act_hit_o[b] = valid_i && (op == OP_ACT) && sel;
        assign rw_hit_o[b]  = valid_i && ((op == OP_RD) || (op == OP_WR)) && sel;
        assign pre_hit_o[b] = valid_i && (op == OP_PRE) && (a10_i || sel);
    end

endmodule

// File: rtl/sbt_bank_slot.sv
module sbt_bank_slot
    import sbt_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int TRP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_hit_i,
    input  logic             rw_hit_i,
    input  logic             pre_hit_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [TRP_W-1:0] trp_i,
    output bank_st_e         state_o,
    output logic [ROW_W-1:0] row_o,
    output logic             rw_ok_o,
    output logic             act_ok_o,
    output logic             bad_cmd_o
);
    typedef struct packed {
        bank_st_e         st;
        logic [TRP_W-1:0] tmr;
        logic [ROW_W-1:0] row;
    } slot_t;

    slot_t s_d, s_q;
    logic  bad_d;

    always_comb begin
        s_d   = s_q;
        bad_d = 1'b0;

        // recovery countdown runs every cycle
        if (s_q.st == BANK_PRECH) begin
            if (s_q.tmr <= TRP_W'(1)) begin
                s_d.st  = BANK_IDLE;
                s_d.tmr = '0;
            end else begin
                s_d.tmr = s_q.tmr - TRP_W'(1);
            end
        end

        if (act_hit_i) begin
            if (s_q.st == BANK_IDLE) begin
                s_d.st  = BANK_OPEN;
                s_d.row = row_i;
            end else begin
                bad_d = 1'b1;
            end
        end

        if (rw_hit_i && (s_q.st != BANK_OPEN)) begin
            bad_d = 1'b1;
        end

        // close: always legal, restarts the count
        if (pre_hit_i) begin
            if (trp_i <= TRP_W'(1)) begin
                s_d.st  = BANK_IDLE;
                s_d.tmr = '0;
            end else begin
                s_d.st  = BANK_PRECH;
                s_d.tmr = trp_i - TRP_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: BANK_IDLE, tmr: '0, row: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign state_o   = s_q.st;
    assign row_o     = s_q.row;
    assign rw_ok_o   = (s_q.st == BANK_OPEN);
    assign act_ok_o  = (s_q.st == BANK_IDLE);
    assign bad_cmd_o = bad_d;

    assert_open_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hit_i && !pre_hit_i && state_o == BANK_IDLE)
        |=> (state_o == BANK_OPEN && row_o == $past(row_i)));

    assert_bad_open_keeps_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hit_i && state_o != BANK_IDLE) |=> $stable(row_o));

    assert_close_recovers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_hit_i && trp_i > TRP_W'(1)) |=> (state_o == BANK_PRECH));

    assert_count_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == BANK_PRECH && s_q.tmr == TRP_W'(1) && !pre_hit_i)
        |=> (state_o == BANK_IDLE));

    assert_rw_closed_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_hit_i && state_o != BANK_OPEN) |-> bad_cmd_o);

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sbt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int TRP_W     = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic [1:0]                   cmd_op,
    input  logic [$clog2(NUM_BANKS)-1:0] cmd_ba,
    input  logic                         cmd_a10,
    input  logic [ROW_W-1:0]             cmd_row,
    input  logic [TRP_W-1:0]             trp_cycles,
    output logic [2*NUM_BANKS-1:0]       bank_state,
    output logic [ROW_W*NUM_BANKS-1:0]   open_row,
    output logic [NUM_BANKS-1:0]         rw_ok,
    output logic [NUM_BANKS-1:0]         act_ok,
    output logic                         viol,
    output logic [$clog2(NUM_BANKS)-1:0] viol_bank
);
    localparam int BA_W = $clog2(NUM_BANKS);

    typedef struct packed {
        logic            flag;
        logic [BA_W-1:0] bank;
    } viol_t;

    logic [NUM_BANKS-1:0] act_hit, rw_hit, pre_hit, bad_cmd;
    bank_st_e             slot_st [NUM_BANKS];
    viol_t                v_d, v_q;

    sbt_cmd_route #(.NUM_BANKS(NUM_BANKS)) u_route (
        .valid_i   (cmd_valid),
        .op_i      (cmd_op),
        .ba_i      (cmd_ba),
        .a10_i     (cmd_a10),
        .act_hit_o (act_hit),
        .rw_hit_o  (rw_hit),
        .pre_hit_o (pre_hit)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sbt_bank_slot #(.ROW_W(ROW_W), .TRP_W(TRP_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_hit_i (act_hit[b]),
            .rw_hit_i  (rw_hit[b]),
            .pre_hit_i (pre_hit[b]),
            .row_i     (cmd_row),
            .trp_i     (trp_cycles),
            .state_o   (slot_st[b]),
            .row_o     (open_row[ROW_W*b +: ROW_W]),
            .rw_ok_o   (rw_ok[b]),
            .act_ok_o  (act_ok[b]),
            .bad_cmd_o (bad_cmd[b])
        );
        assign bank_state[2*b +: 2] = slot_st[b];
    end

    always_comb begin
        v_d = '{flag: 1'b0, bank: '0};
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bad_cmd[b]) begin
                v_d.flag = 1'b1;
                v_d.bank = BA_W'(b);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '{flag: 1'b0, bank: '0};
        end else begin
            v_q <= v_d;
        end
    end

    assign viol      = v_q.flag;
    assign viol_bank = v_q.bank;

    assert_viol_needs_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $past(cmd_valid));

    assert_idle_no_viol_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !viol);

    assert_all_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b11 && cmd_a10 && trp_cycles > TRP_W'(1))
        |=> (act_ok == '0 && rw_ok == '0));

    assert_one_bad_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bad_cmd));

endmodule

// File: tb/sim_sdram_bank_tracker.sv
module sim_sdram_bank_tracker;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]  st;
        logic [3:0]  rw;
        logic [3:0]  act;
        logic        viol;
        logic [1:0]  vb;
        logic [47:0] rows;
    } obs_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [1:0]  cmd_ba = 2'b00;
    logic        cmd_a10 = 1'b0;
    logic [11:0] cmd_row = '0;
    logic [3:0]  trp_cycles = 4'd3;
    logic [7:0]  bank_state;
    logic [47:0] open_row;
    logic [3:0]  rw_ok, act_ok;
    logic        viol;
    logic [1:0]  viol_bank;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    obs_t  exp_q[$];
    string tag_q[$];

    int          mst [4];
    int          mt  [4];
    logic [11:0] mrow[4];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_bank_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ba(cmd_ba), .cmd_a10(cmd_a10), .cmd_row(cmd_row),
        .trp_cycles(trp_cycles), .bank_state(bank_state), .open_row(open_row),
        .rw_ok(rw_ok), .act_ok(act_ok), .viol(viol), .viol_bank(viol_bank)
    );

    function automatic obs_t model_obs(input logic v, input logic [1:0] vb);
        obs_t o;
        o.viol = v;
        o.vb   = vb;
        for (int b = 0; b < 4; b++) begin
            o.st[2*b +: 2]    = 2'(mst[b]);
            o.rw[b]           = (mst[b] == 1);
            o.act[b]          = (mst[b] == 0);
            o.rows[12*b +: 12] = mrow[b];
        end
        return o;
    endfunction

    // driver: applies one command at the falling edge and queues the expectation
    task automatic step(input logic v, input logic [1:0] op, input logic [1:0] ba,
                        input logic a10, input logic [11:0] row, input string tag);
        int          nst[4];
        int          nt[4];
        logic [11:0] nrow[4];
        logic        bad = 1'b0;
        logic [1:0]  bb = 2'd0;
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_ba = ba; cmd_a10 = a10; cmd_row = row;
        for (int b = 0; b < 4; b++) begin
            nst[b] = mst[b]; nt[b] = mt[b]; nrow[b] = mrow[b];
            if (mst[b] == 2) begin
                if (mt[b] <= 1) begin nst[b] = 0; nt[b] = 0; end
                else nt[b] = mt[b] - 1;
            end
        end
        if (v) begin
            case (op)
                2'b00: if (mst[ba] == 0) begin nst[ba] = 1; nrow[ba] = row; end
                       else begin bad = 1'b1; bb = ba; end
                2'b01, 2'b10: if (mst[ba] != 1) begin bad = 1'b1; bb = ba; end
                default: for (int b = 0; b < 4; b++) begin
                    if (a10 || b == int'(ba)) begin
                        if (trp_cycles <= 4'd1) begin nst[b] = 0; nt[b] = 0; end
                        else begin nst[b] = 2; nt[b] = int'(trp_cycles) - 1; end
                    end
                end
            endcase
        end
        for (int b = 0; b < 4; b++) begin
            mst[b] = nst[b]; mt[b] = nt[b]; mrow[b] = nrow[b];
        end
        exp_q.push_back(model_obs(bad, bb));
        tag_q.push_back(tag);
    endtask

    // monitor: compares just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                obs_t  e;
                obs_t  g;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                g = '{st: bank_state, rw: rw_ok, act: act_ok, viol: viol,
                      vb: viol_bank, rows: open_row};
                checks++;
                if (g !== e) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", t, g, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 4; b++) begin mst[b] = 0; mt[b] = 0; mrow[b] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset values observed while reset is held
        checks++;
        if ({bank_state, rw_ok, act_ok, viol} !== {8'h00, 4'h0, 4'hF, 1'b0}) begin
            failures++;
            $display("FAIL R1 actual=%h expected=%h",
                     {bank_state, rw_ok, act_ok, viol}, {8'h00, 4'h0, 4'hF, 1'b0});
        end
        rst_n = 1'b1;
        step(0, 2'b00, 2'd0, 0, 12'h000, "R1 idle after reset");
        step(1, 2'b01, 2'd2, 0, 12'h000, "R3 read closed bank");
        step(0, 2'b00, 2'd0, 0, 12'h000, "R3 flag one cycle");
        step(1, 2'b10, 2'd3, 0, 12'h000, "R3 write closed bank");
        step(1, 2'b00, 2'd1, 0, 12'h123, "R2 open bank1");
        step(1, 2'b01, 2'd1, 0, 12'h000, "R2 read open bank");
        step(1, 2'b10, 2'd1, 0, 12'h000, "R2 write open bank");
        step(1, 2'b00, 2'd1, 0, 12'h777, "R4 open already open");
        step(1, 2'b00, 2'd0, 0, 12'hABC, "R2 open bank0");
        step(1, 2'b00, 2'd3, 0, 12'h055, "R2 open bank3");
        step(1, 2'b11, 2'd1, 0, 12'h000, "R5 close bank1 only");
        step(1, 2'b00, 2'd1, 0, 12'h999, "R7 open at k+1");
        step(1, 2'b00, 2'd1, 0, 12'h999, "R7 open at k+2");
        step(1, 2'b00, 2'd1, 0, 12'h321, "R7 open at k+3");
        step(1, 2'b11, 2'd2, 1, 12'h000, "R6 close all");
        step(1, 2'b11, 2'd0, 0, 12'h000, "R8 close recovering");
        step(1, 2'b01, 2'd0, 0, 12'h000, "R3 read recovering");
        step(0, 2'b00, 2'd0, 0, 12'h000, "R7 count runs");
        step(1, 2'b00, 2'd0, 0, 12'h444, "R8 restarted count");
        step(1, 2'b00, 2'd0, 0, 12'h444, "R7 restarted boundary");
        step(0, 2'b00, 2'd2, 0, 12'h000, "R9 settle");
        step(1, 2'b11, 2'd2, 0, 12'h000, "R8 close idle bank");
        step(0, 2'b00, 2'd2, 0, 12'h111, "R9 ignored open");
        step(0, 2'b01, 2'd3, 0, 12'h000, "R9 ignored read");
        step(0, 2'b11, 2'd0, 1, 12'h000, "R9 ignored close");
        trp_cycles = 4'd1;
        step(1, 2'b11, 2'd0, 0, 12'h000, "R7 close trp1");
        step(1, 2'b00, 2'd0, 0, 12'h5A5, "R7 open after trp1");
        trp_cycles = 4'd0;
        step(1, 2'b11, 2'd3, 0, 12'h000, "R7 close trp0");
        step(1, 2'b00, 2'd3, 0, 12'h0F0, "R7 open after trp0");
        step(1, 2'b10, 2'd3, 0, 12'h000, "R2 write reopened");
        step(0, 2'b00, 2'd0, 0, 12'h000, "R9 final idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule